// File: doc/BRIEF.md
# Challenge Scratchpad

This block holds a 64-bit challenge in eight byte registers, ready for a downstream hash engine. A host loads it one byte at a time through a write command. It reads it back one bit at a time through a read command that starts at a chosen byte address. The stored value is always visible in parallel on a 64-bit output, so the hash engine never has to take part in the byte or bit traffic.

Three command events drive a single mode register: a write start, a read start and a bus reset. Only one command is live at a time. Starting one command ends the other, and a bus reset ends either one. None of these events changes the stored bytes; only the chip reset clears them.

Top module: `chal_scratchpad`

## Requirements
- R1: After `rst_n` is asserted low, `challenge` is all zeros, no command is active, and `rd_bit` is 1.
- R2: A write command begins on a cycle with `wr_start` high. Each later cycle with `wr_valid` high stores `wr_byte` into the next byte slot, filling slot 0 first and slot 7 last.
- R3: A read command begins on a cycle with `rd_start` high, and that cycle loads `rd_addr` as the byte address. Each `rd_req` cycle moves to the next bit. After the eighth bit of a byte, the address goes up by one.
- R4: While the read address is above 7, `rd_bit` is 1. The address stops at 255 and never wraps back into the valid window.
- R5: Within a byte, bits come out least significant first, and bit 0 of the start byte is presented on `rd_bit` in the cycle after `rd_start`.
- R6: The following `wr_valid` cycles change nothing: a ninth or later byte in one write command, a byte sent with no write command active, and a byte sent in the same cycle as `wr_start`.
- R7: `bus_rst` ends any active command and keeps every stored byte. Afterwards `rd_bit` is 1 and `wr_valid` is ignored until a new start.
- R8: `challenge` holds byte slot k in bits 8k+7:8k and shows an accepted byte from the clock edge that accepts it.
- R9: A write start ends an active read, and a read start ends an active write. `bus_rst` takes priority over both starts, and `wr_start` takes priority over `rd_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous chip reset, active low; clears contents |
| bus_rst | input | 1 | Ends the current command, contents kept |
| wr_start | input | 1 | Begins a write command at slot 0 |
| wr_valid | input | 1 | Byte strobe for the write command |
| wr_byte | input | 8 | Byte to store |
| rd_start | input | 1 | Begins a read command at `rd_addr` |
| rd_addr | input | 8 | Start byte address for a read |
| rd_req | input | 1 | Consumes the current read bit and moves to the next |
| rd_bit | output | 1 | Current read bit; 1 when idle or out of range |
| challenge | output | 64 | Stored challenge, slot 0 in bits 7:0 |

## Verification
The bench targets three kinds of mistake.

The first is at the end of the address window. A read starting at byte 6 must give two real bytes and then ones, and a read starting at 254 must stay at ones. A design that wraps the address would show byte 0 again.

The second is bit order and the write fill. An MSB-first design, or one that stores the first byte in slot 7, would show up as mismatches at once. A ninth byte, a stray `wr_valid`, or a byte sent in the start cycle would overwrite a slot in a design without the guards.

The third is the command events. After a bus reset in the middle of a write, the partly written value must stay, and `rd_bit` must fall back to 1. A design that clears on bus reset, or keeps reading after it, fails here.

// File: rtl/chal_sp_pkg.sv
package chal_sp_pkg;

  localparam int CSP_NBYTES = 8;
  localparam int CSP_BYTE_W = 8;
  localparam int CSP_ADDR_W = 8;

  typedef enum logic [1:0] {
    CSP_IDLE  = 2'd0,
    CSP_WRITE = 2'd1,
    CSP_READ  = 2'd2
  } csp_mode_e;

endpackage

// File: rtl/chal_sp_ctrl.sv
module chal_sp_ctrl
  import chal_sp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_rst,
  input  logic      wr_start,
  input  logic      rd_start,
  output csp_mode_e mode_o,
  output logic      wr_restart_o,
  output logic      rd_load_o,
  output logic      cmd_evt_o
);

  csp_mode_e mode_q;

  // Priority order: bus reset, then write start, then read start.
  assign wr_restart_o = !bus_rst && wr_start;
  assign rd_load_o    = !bus_rst && !wr_start && rd_start;
  assign cmd_evt_o    = bus_rst || wr_start || rd_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mode_q <= CSP_IDLE;
    else if (bus_rst)      mode_q <= CSP_IDLE;
    else if (wr_start)     mode_q <= CSP_WRITE;
    else if (rd_start)     mode_q <= CSP_READ;
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/chal_sp_store.sv
module chal_sp_store #(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8,
  localparam int PTR_W   = $clog2(NBYTES + 1),
  localparam int TOTAL_W = NBYTES * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               wr_en,
  input  logic [BYTE_W-1:0]  wr_byte,
  output logic [TOTAL_W-1:0] data_o,
  output logic [PTR_W-1:0]   ptr_o,
  output logic               take_o
);

  logic [PTR_W-1:0] ptr_q;
  logic             take;

  // A byte is taken only while the fill pointer is inside the window.
  function automatic logic has_room(input logic [PTR_W-1:0] p);
    return p < PTR_W'(NBYTES);
  endfunction

  assign take = wr_en && has_room(ptr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (restart) ptr_q <= '0;
    else if (take)    ptr_q <= ptr_q + PTR_W'(1);
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    logic [BYTE_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot_q <= '0;
      else if (take && ptr_q == PTR_W'(g))     slot_q <= wr_byte;
    end
    assign data_o[g*BYTE_W +: BYTE_W] = slot_q;
  end

  assign ptr_o  = ptr_q;
  assign take_o = take;

endmodule

// File: rtl/chal_sp_reader.sv
module chal_sp_reader #(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 8,
  localparam int BIT_W   = $clog2(BYTE_W),
  localparam int TOTAL_W = NBYTES * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ADDR_W-1:0]  load_addr,
  input  logic               adv,
  input  logic               active,
  input  logic [TOTAL_W-1:0] data_i,
  output logic               bit_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [BIT_W-1:0]   pos_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  pos_q;
  logic              last_bit;

  // Address steps up but stops at its top value instead of wrapping.
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return (a == '1) ? a : a + ADDR_W'(1);
  endfunction

  // Bit at (byte a, bit p); outside the window the answer is 1.
  function automatic logic pick_bit(input logic [TOTAL_W-1:0] d,
                                    input logic [ADDR_W-1:0]  a,
                                    input logic [BIT_W-1:0]   p);
    logic [TOTAL_W-1:0] sh;
    int                 idx;
    if (a >= ADDR_W'(NBYTES)) return 1'b1;
    idx = int'(a) * BYTE_W + int'(p);
    sh  = d >> idx;
    return sh[0];
  endfunction

  assign last_bit = (pos_q == BIT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pos_q  <= '0;
    end else if (load) begin
      addr_q <= load_addr;
      pos_q  <= '0;
    end else if (adv) begin
      pos_q <= last_bit ? '0 : pos_q + BIT_W'(1);
      if (last_bit) addr_q <= step_addr(addr_q);
    end
  end

  assign bit_o  = active ? pick_bit(data_i, addr_q, pos_q) : 1'b1;
  assign addr_o = addr_q;
  assign pos_o  = pos_q;

endmodule

// File: rtl/chal_scratchpad.sv
module chal_scratchpad
  import chal_sp_pkg::*;
#(
  parameter int NBYTES = CSP_NBYTES,
  parameter int BYTE_W = CSP_BYTE_W,
  parameter int ADDR_W = CSP_ADDR_W,
  localparam int PTR_W   = $clog2(NBYTES + 1),
  localparam int BIT_W   = $clog2(BYTE_W),
  localparam int TOTAL_W = NBYTES * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rst,
  input  logic               wr_start,
  input  logic               wr_valid,
  input  logic [BYTE_W-1:0]  wr_byte,
  input  logic               rd_start,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_req,
  output logic               rd_bit,
  output logic [TOTAL_W-1:0] challenge
);

  csp_mode_e         mode;
  logic              wr_restart;
  logic              rd_load;
  logic              cmd_evt;
  logic              wr_en;
  logic              rd_adv;
  logic              rd_act;
  logic              wr_take;
  logic [PTR_W-1:0]  wr_ptr;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [BIT_W-1:0]  rd_pos;

  chal_sp_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rst      (bus_rst),
    .wr_start     (wr_start),
    .rd_start     (rd_start),
    .mode_o       (mode),
    .wr_restart_o (wr_restart),
    .rd_load_o    (rd_load),
    .cmd_evt_o    (cmd_evt)
  );

  // A command event in a cycle overrides any data strobe in that cycle.
  assign wr_en  = (mode == CSP_WRITE) && wr_valid && !cmd_evt;
  assign rd_act = (mode == CSP_READ);
  assign rd_adv = rd_act && rd_req && !cmd_evt;

  chal_sp_store #(
    .NBYTES (NBYTES),
    .BYTE_W (BYTE_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_restart),
    .wr_en   (wr_en),
    .wr_byte (wr_byte),
    .data_o  (challenge),
    .ptr_o   (wr_ptr),
    .take_o  (wr_take)
  );

  chal_sp_reader #(
    .NBYTES (NBYTES),
    .BYTE_W (BYTE_W),
    .ADDR_W (ADDR_W)
  ) u_reader (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_load),
    .load_addr (rd_addr),
    .adv       (rd_adv),
    .active    (rd_act),
    .data_i    (challenge),
    .bit_o     (rd_bit),
    .addr_o    (rd_addr_q),
    .pos_o     (rd_pos)
  );

endmodule

// File: rtl/chal_sp_checker.sv
module chal_sp_checker
  import chal_sp_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 8,
  localparam int PTR_W   = $clog2(NBYTES + 1),
  localparam int BIT_W   = $clog2(BYTE_W),
  localparam int TOTAL_W = NBYTES * BYTE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_rst,
  input logic               wr_start,
  input logic               rd_start,
  input logic               rd_req,
  input logic               rd_bit,
  input logic [TOTAL_W-1:0] challenge,
  input csp_mode_e          mode,
  input logic               wr_take,
  input logic [PTR_W-1:0]   wr_ptr,
  input logic [ADDR_W-1:0]  rd_addr_q,
  input logic [BIT_W-1:0]   rd_pos
);

  logic quiet;
  assign quiet = !bus_rst && !wr_start && !rd_start;

  AST_BEYOND_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CSP_READ && rd_addr_q >= ADDR_W'(NBYTES)) |-> rd_bit); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CSP_READ && rd_req && quiet && rd_pos == BIT_W'(BYTE_W - 1) && rd_addr_q != '1)
      |=> rd_addr_q == $past(rd_addr_q) + ADDR_W'(1)); // R3

  AST_ADDR_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CSP_READ && rd_addr_q == '1 && quiet) |=> rd_addr_q == '1); // R4

  AST_LSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !bus_rst && !wr_start) |=> (rd_pos == '0 && mode == CSP_READ)); // R5

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> wr_ptr == $past(wr_ptr) + PTR_W'(1)); // R2

  AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr == PTR_W'(NBYTES)) |=> $stable(challenge)); // R6

  AST_NO_TAKE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != CSP_WRITE || !quiet) |-> !wr_take); // R6

  AST_BUSRST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (mode == CSP_IDLE && $stable(challenge) && rd_bit)); // R7

  AST_START_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && !bus_rst) |=> (mode == CSP_WRITE && wr_ptr == '0)); // R9

endmodule

bind chal_scratchpad chal_sp_checker #(
  .NBYTES (NBYTES),
  .BYTE_W (BYTE_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rst   (bus_rst),
  .wr_start  (wr_start),
  .rd_start  (rd_start),
  .rd_req    (rd_req),
  .rd_bit    (rd_bit),
  .challenge (challenge),
  .mode      (mode),
  .wr_take   (wr_take),
  .wr_ptr    (wr_ptr),
  .rd_addr_q (rd_addr_q),
  .rd_pos    (rd_pos)
);

// File: tb/chal_scratchpad_tb.sv
`timescale 1ns/1ps
module chal_scratchpad_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst = 1'b0;
  logic        wr_start = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_byte = 8'h00;
  logic        rd_start = 1'b0;
  logic [7:0]  rd_addr = 8'h00;
  logic        rd_req = 1'b0;
  logic        rd_bit;
  logic [63:0] challenge;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chal_scratchpad u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rst   (bus_rst),
    .wr_start  (wr_start),
    .wr_valid  (wr_valid),
    .wr_byte   (wr_byte),
    .rd_start  (rd_start),
    .rd_addr   (rd_addr),
    .rd_req    (rd_req),
    .rd_bit    (rd_bit),
    .challenge (challenge)
  );

  // Behavioural reference: a byte array plus a few integers.
  logic [7:0] m [8];
  int mmode = 0;   // 0 idle, 1 writing, 2 reading
  int wptr = 0;
  int raddr = 0;
  int rbit = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m[i] = 8'h00;
      mmode = 0; wptr = 0; raddr = 0; rbit = 0;
    end else if (bus_rst) begin
      mmode = 0;
    end else if (wr_start) begin
      mmode = 1; wptr = 0;
    end else if (rd_start) begin
      mmode = 2; raddr = int'(rd_addr); rbit = 0;
    end else begin
      if (mmode == 1 && wr_valid && wptr < 8) begin
        m[wptr] = wr_byte;
        wptr++;
      end
      if (mmode == 2 && rd_req) begin
        rbit++;
        if (rbit == 8) begin
          rbit = 0;
          if (raddr < 255) raddr++;
        end
      end
    end
  end

  function automatic logic [63:0] model_value();
    logic [63:0] v = '0;
    for (int i = 0; i < 8; i++) v = v | (64'(m[i]) << (8 * i));
    return v;
  endfunction

  function automatic logic model_bit();
    if (mmode != 2) return 1'b1;
    if (raddr > 7) return 1'b1;
    return m[raddr][rbit];
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8", "parallel value", challenge, model_value());
      if (mmode != 2)      chk("R7", "idle read bit", 64'(rd_bit), 64'(model_bit()));
      else if (raddr > 7)  chk("R4", "out of window bit", 64'(rd_bit), 64'(model_bit()));
      else                 chk("R5", "read bit", 64'(rd_bit), 64'(model_bit()));
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic start_write();
    wr_start = 1'b1; step(); wr_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    wr_valid = 1'b1; wr_byte = b; step(); wr_valid = 1'b0;
  endtask

  task automatic start_read(input logic [7:0] a);
    rd_start = 1'b1; rd_addr = a; step(); rd_start = 1'b0;
  endtask

  task automatic take_bits(input int n, output logic [63:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      got[i] = rd_bit;
      rd_req = 1'b1; step(); rd_req = 1'b0;
    end
  endtask

  initial begin
    logic [63:0] got;
    step(); step();
    // R1: reset state
    chk("R1", "reset value", challenge, 64'h0);
    chk("R1", "reset read bit", 64'(rd_bit), 64'h1);
    rst_n = 1'b1; step();
    chk("R1", "after release", challenge, 64'h0);

    // R2 / R8: fill in order
    start_write();
    send_byte(8'h01); send_byte(8'h23); send_byte(8'h45); send_byte(8'h67);
    send_byte(8'h89); send_byte(8'hAB); send_byte(8'hCD); send_byte(8'hEF);
    chk("R2", "full fill", challenge, 64'hEFCDAB8967452301);
    // R6: extra bytes ignored
    send_byte(8'h99); send_byte(8'h11);
    chk("R6", "ninth byte ignored", challenge, 64'hEFCDAB8967452301);

    // R5 / R3: read all from 0
    start_read(8'h00);
    take_bits(8, got);
    chk("R5", "first byte lsb first", got, 64'h01);
    take_bits(56, got);
    chk("R3", "auto increment", got, 64'h00EFCDAB89674523);
    take_bits(8, got);
    chk("R4", "past end ones", got, 64'hFF);

    // R4: start near end of window
    start_read(8'h06);
    take_bits(32, got);
    chk("R4", "tail then ones", got, 64'hFFFFEFCD);

    // R4: saturation at top address
    start_read(8'hFE);
    take_bits(24, got);
    chk("R4", "no wrap at top", got, 64'hFFFFFF);

    // R6: stray strobes ignored
    send_byte(8'h55);
    chk("R6", "strobe while reading", challenge, 64'hEFCDAB8967452301);
    bus_rst = 1'b1; step(); bus_rst = 1'b0;
    send_byte(8'h66);
    chk("R6", "strobe while idle", challenge, 64'hEFCDAB8967452301);
    wr_start = 1'b1; wr_valid = 1'b1; wr_byte = 8'h77; step();
    wr_start = 1'b0; wr_valid = 1'b0;
    chk("R6", "byte in start cycle", challenge, 64'hEFCDAB8967452301);

    // R7: bus reset mid write keeps partial contents
    send_byte(8'h5A); send_byte(8'hA5); send_byte(8'hC3);
    bus_rst = 1'b1; step(); bus_rst = 1'b0;
    send_byte(8'h44);
    chk("R7", "partial kept", challenge, 64'hEFCDAB8967C3A55A);

    // R7: bus reset mid read
    start_read(8'h01);
    take_bits(3, got);
    bus_rst = 1'b1; step(); bus_rst = 1'b0;
    chk("R7", "read ended", 64'(rd_bit), 64'h1);

    // R9: write start ends read, read start ends write
    start_read(8'h00);
    take_bits(2, got);
    start_write();
    chk("R9", "read ended by write", 64'(rd_bit), 64'h1);
    send_byte(8'h12);
    start_read(8'h00);
    send_byte(8'h34);
    chk("R9", "write ended by read", challenge, 64'hEFCDAB8967C3A512);
    take_bits(8, got);
    chk("R9", "read after switch", got, 64'h12);

    // R9: bus reset beats a start in the same cycle
    bus_rst = 1'b1; rd_start = 1'b1; rd_addr = 8'h00; step();
    bus_rst = 1'b0; rd_start = 1'b0;
    chk("R9", "bus reset priority", 64'(rd_bit), 64'h1);

    // R1: chip reset clears contents
    rst_n = 1'b0; step();
    chk("R1", "second reset", challenge, 64'h0);
    rst_n = 1'b1; step(); step();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule